// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo serial audio stream into parallel samples. The stream arrives on three wires: a bit clock, a frame clock that selects the left or right channel, and a data line. All three are oversampled by a faster system clock, which is the only clock inside the block. A three-bit format code, which may change between streams, selects one of five framings. Three are right-aligned (16, 20 or 24 bits), one is left-aligned and one is left-aligned with a one-bit delay. The left-aligned delayed framing also reverses which frame-clock level marks the left channel.

For every frame, the block presents a 24-bit two's-complement left sample and right sample together, with a one-cycle valid strobe. Right-aligned words shorter than 24 bits are sign-extended. Left-aligned words are placed at the top of the 24-bit field. One shift engine serves every framing. Its bit counter restarts on each frame-clock edge, so an irregular half frame corrupts at most that half.

Top module: `srx_rx`

## Requirements
- R1: The format code selects the framing as follows: 000 = 16-bit right-aligned, 001 = 20-bit right-aligned, 010 = 24-bit left-aligned, 011 = 24-bit left-aligned with one-bit delay, 100 = 24-bit right-aligned. The codes 101, 110 and 111 behave as 010.
- R2: The data line is sampled on each rising edge of the bit clock, and each word is received most significant bit first.
- R3: In format 010, the most significant bit is the first bit after a frame-clock edge and bits after the 24th are ignored. A half frame with fewer than 24 bits yields its bits at the top of the word, with the remaining low bits at zero.
- R4: In format 011, the first bit after a frame-clock edge is ignored, the word starts on the second bit, and the left channel is the half frame with the frame clock low.
- R5: In formats other than 011, the left channel is the half frame with the frame clock high.
- R6: In formats 000, 001 and 100, the word is the last 16, 20 or 24 bits before the frame-clock edge that ends the half frame. Earlier bits are ignored. The word is sign-extended from its top bit to 24 bits, so 7FFF gives 007FFF and 8000 gives FF8000.
- R7: When a right half frame ends with a left word already held, the left and right samples are driven together with valid high for exactly one system cycle. Both sample outputs stay unchanged between pulses.
- R8: The bit count restarts at each frame-clock edge. A half frame longer or shorter than its neighbours does not change the sample decoded from any other half frame.
- R9: During and after reset, valid is low and both samples are zero. Bits received before the first frame-clock edge are discarded. A right word that ends without a left word held since the last pulse or reset produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial bit clock |
| fclk_i | input | 1 | Frame clock (channel select) |
| sdat_i | input | 1 | Serial data line |
| fmt_i | input | 3 | Framing format code |
| left_o | output | 24 | Left sample, two's complement |
| right_o | output | 24 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
Each format is driven with full-scale positive and negative words, a one-LSB word and random words, with random filler on every bit the format should ignore. This separates correct alignment and sign extension from bit slips, and exposes any leakage of ignored bits. Streams with irregular half-frame lengths separate a counter that restarts on each frame edge from one that runs free. Short half frames in left-aligned mode check the zero padding. A leading left-over half frame and an orphan right half check that only complete left and right pairs produce a strobe.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int unsigned WORD_W  = 24;
    localparam int unsigned SHORT_W = 16;
    localparam int unsigned MID_W   = 20;
    localparam int unsigned CNT_W   = $clog2(WORD_W + 1);

    typedef enum logic [2:0] {
        FMT_TAIL16 = 3'b000,
        FMT_TAIL20 = 3'b001,
        FMT_HEAD24 = 3'b010,
        FMT_DLY24  = 3'b011,
        FMT_TAIL24 = 3'b100
    } fmt_e;

    // framing parameters derived from the format code
    typedef struct packed {
        logic             tail_align;   // word ends on the last bit of the half
        logic [CNT_W-1:0] tail_w;       // word width for tail-aligned framings
        logic             lead_skip;    // ignore the first bit after an edge
        logic             left_on_high; // frame clock level marking left
    } frame_cfg_t;

    // one sampled bit-clock event
    typedef struct packed {
        logic rise;
        logic fedge;
        logic lr;
        logic dat;
    } bit_evt_t;

    // one finished half-frame word
    typedef struct packed {
        logic              vld;
        logic              is_left;
        logic [WORD_W-1:0] word;
    } word_evt_t;

    function automatic frame_cfg_t decode_fmt(input logic [2:0] code);
        frame_cfg_t c;
        c = '{tail_align: 1'b0, tail_w: CNT_W'(WORD_W),
              lead_skip: 1'b0, left_on_high: 1'b1};
        case (fmt_e'(code))
            FMT_TAIL16: begin
                c.tail_align = 1'b1;
                c.tail_w     = CNT_W'(SHORT_W);
            end
            FMT_TAIL20: begin
                c.tail_align = 1'b1;
                c.tail_w     = CNT_W'(MID_W);
            end
            FMT_TAIL24: begin
                c.tail_align = 1'b1;
                c.tail_w     = CNT_W'(WORD_W);
            end
            FMT_DLY24: begin
                c.lead_skip    = 1'b1;
                c.left_on_high = 1'b0;
            end
            default: ;
        endcase
        return c;
    endfunction

    // keep the low w bits and replicate bit w-1 above them
    function automatic logic [WORD_W-1:0] sign_fit(input logic [WORD_W-1:0] raw,
                                                   input logic [CNT_W-1:0]  w);
        logic              sb;
        logic [WORD_W-1:0] r;
        sb = 1'b0;
        for (int i = 0; i < int'(WORD_W); i++) begin
            if (i == int'(w) - 1) sb = raw[i];
        end
        for (int i = 0; i < int'(WORD_W); i++) begin
            r[i] = (i < int'(w)) ? raw[i] : sb;
        end
        return r;
    endfunction

    // move the cnt received bits to the top, zero below
    function automatic logic [WORD_W-1:0] top_align(input logic [WORD_W-1:0] raw,
                                                    input logic [CNT_W-1:0]  cnt);
        int unsigned s;
        s = WORD_W - int'(cnt);
        return raw << s;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int unsigned W = 3,
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(N); i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < int'(N); i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[N-1];

endmodule

// File: rtl/srx_sampler.sv
module srx_sampler
    import srx_pkg::*;
#(
    parameter int unsigned SYNC_N = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_i,
    input  logic     fclk_i,
    input  logic     sdat_i,
    output bit_evt_t evt_o
);

    localparam int unsigned LANES = 3;
    localparam int unsigned L_SCK = 2;
    localparam int unsigned L_FCK = 1;
    localparam int unsigned L_DAT = 0;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;
    logic             sck_prev_q;
    logic             lr_last_q;
    logic             seen_q;
    logic             rise;

    assign raw = {sclk_i, fclk_i, sdat_i};

    srx_sync #(.W(LANES), .N(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (synced)
    );

    assign rise = synced[L_SCK] & ~sck_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev_q <= 1'b0;
            lr_last_q  <= 1'b0;
            seen_q     <= 1'b0;
        end else begin
            sck_prev_q <= synced[L_SCK];
            if (rise) begin
                lr_last_q <= synced[L_FCK];
                seen_q    <= 1'b1;
            end
        end
    end

    always_comb begin
        evt_o = '{rise:  rise,
                  fedge: rise & seen_q & (synced[L_FCK] ^ lr_last_q),
                  lr:    synced[L_FCK],
                  dat:   synced[L_DAT]};
    end

endmodule

// File: rtl/srx_shift.sv
module srx_shift
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bit_evt_t   evt_i,
    input  frame_cfg_t cfg_i,
    output word_evt_t  word_o
);

    logic [WORD_W-1:0] acc_q, acc_base, acc_nx, fin_word;
    logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_nx;
    logic              half_lr_q;
    logic              armed_q;
    logic              take;
    logic              room;

    always_comb begin
        acc_base = evt_i.fedge ? '0 : acc_q;
        cnt_base = evt_i.fedge ? '0 : cnt_q;
        room     = cnt_base < CNT_W'(WORD_W);
        if (cfg_i.tail_align) begin
            take = 1'b1;
        end else begin
            take = room && !(cfg_i.lead_skip && evt_i.fedge);
        end
        acc_nx = take ? {acc_base[WORD_W-2:0], evt_i.dat} : acc_base;
        cnt_nx = (take && room) ? cnt_base + CNT_W'(1) : cnt_base;
        fin_word = cfg_i.tail_align ? sign_fit(acc_q, cfg_i.tail_w)
                                    : top_align(acc_q, cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            half_lr_q <= 1'b0;
            armed_q   <= 1'b0;
            word_o    <= '0;
        end else begin
            word_o.vld <= 1'b0;
            if (evt_i.rise) begin
                acc_q <= acc_nx;
                cnt_q <= cnt_nx;
                if (evt_i.fedge) begin
                    armed_q   <= 1'b1;
                    half_lr_q <= evt_i.lr;
                    if (armed_q) begin
                        word_o <= '{vld:     1'b1,
                                    is_left: (half_lr_q == cfg_i.left_on_high),
                                    word:    fin_word};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/srx_pair.sv
module srx_pair
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  word_evt_t         word_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o
);

    logic [WORD_W-1:0] hold_l_q;
    logic              have_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_l_q <= '0;
            have_q   <= 1'b0;
            left_o   <= '0;
            right_o  <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (word_i.vld) begin
                if (word_i.is_left) begin
                    hold_l_q <= word_i.word;
                    have_q   <= 1'b1;
                end else if (have_q) begin
                    left_o  <= hold_l_q;
                    right_o <= word_i.word;
                    valid_o <= 1'b1;
                    have_q  <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/srx_rx.sv
module srx_rx
    import srx_pkg::*;
#(
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              fclk_i,
    input  logic              sdat_i,
    input  logic [2:0]        fmt_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o
);

    bit_evt_t   smp_evt;
    frame_cfg_t cfg;
    word_evt_t  half_word;

    assign cfg = decode_fmt(fmt_i);

    srx_sampler #(.SYNC_N(SYNC_N)) u_smp (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .fclk_i (fclk_i),
        .sdat_i (sdat_i),
        .evt_o  (smp_evt)
    );

    srx_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (smp_evt),
        .cfg_i  (cfg),
        .word_o (half_word)
    );

    srx_pair u_pair (
        .clk     (clk),
        .rst     (rst),
        .word_i  (half_word),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/srx_rx_chk.sv
module srx_rx_chk
    import srx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [WORD_W-1:0] left_i,
    input logic [WORD_W-1:0] right_i,
    input logic              fedge_i
);

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> !valid_i);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !$past(rst)) |-> ($stable(left_i) && $stable(right_i)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!valid_i && left_i == '0 && right_i == '0));

    // R8
    edge_src_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |-> $past(fedge_i, 2));

endmodule

bind srx_rx srx_rx_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_o),
    .left_i  (left_o),
    .right_i (right_o),
    .fedge_i (smp_evt.fedge)
);

// File: tb/srx_rx_bench.sv
module srx_rx_bench;

    localparam int HB = 4;

    logic        clk  = 1'b0;
    logic        rst  = 1'b1;
    logic        sclk = 1'b0;
    logic        fclk = 1'b0;
    logic        sdat = 1'b0;
    logic [2:0]  fmt  = 3'b010;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    always #2 clk = ~clk;

    srx_rx u_srx_rx (
        .clk     (clk),
        .rst     (rst),
        .sclk_i  (sclk),
        .fclk_i  (fclk),
        .sdat_i  (sdat),
        .fmt_i   (fmt),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [23:0] q_l[$];
    logic [23:0] q_r[$];
    logic [23:0] cur_l = '0;
    logic [23:0] cur_r = '0;
    string       req = "R9";
    bit          done = 1'b0;

    // reference comparison on every clock
    always @(negedge clk) begin
        if (rst) begin
            cur_l = '0;
            cur_r = '0;
        end else begin
            if (valid_o) begin
                n_chk++;
                if (q_l.size() == 0) begin
                    n_fail++;
                    $display("FAIL %s R7: pulse with no frame due (got %h %h, expected none)",
                             req, left_o, right_o);
                end else begin
                    cur_l = q_l.pop_front();
                    cur_r = q_r.pop_front();
                end
            end
            n_chk++;
            if (left_o !== cur_l || right_o !== cur_r) begin
                n_fail++;
                $display("FAIL %s: samples got %h %h, expected %h %h",
                         req, left_o, right_o, cur_l, cur_r);
            end
        end
    end

    function automatic logic bit_for(input logic [2:0] m, input logic [23:0] w,
                                     input int k, input int nb);
        int n;
        int j;
        case (m)
            3'b000:  n = 16;
            3'b001:  n = 20;
            3'b100:  n = 24;
            default: n = 0;
        endcase
        if (n != 0) begin
            j = nb - 1 - k;
            if (j < n) return w[j];
            return 1'($urandom);
        end
        if (m == 3'b011) begin
            if (k >= 1 && k <= 24) return w[24-k];
            return 1'($urandom);
        end
        if (k < 24) return w[23-k];
        return 1'($urandom);
    endfunction

    function automatic logic [23:0] exp_word(input logic [2:0] m, input logic [23:0] w,
                                             input int nb);
        int take;
        case (m)
            3'b000: return {{8{w[15]}}, w[15:0]};
            3'b001: return {{4{w[19]}}, w[19:0]};
            3'b100: return w;
            default: begin
                take = (m == 3'b011) ? nb - 1 : nb;
                if (take > 24) take = 24;
                return w & ~(24'hFFFFFF >> take);
            end
        endcase
    endfunction

    task automatic drive_bit(input logic lr, input logic b);
        sclk = 1'b0;
        fclk = lr;
        sdat = b;
        repeat (HB) @(negedge clk);
        sclk = 1'b1;
        repeat (HB) @(negedge clk);
    endtask

    task automatic send_half(input logic lr, input logic [2:0] m,
                             input logic [23:0] w, input int nb);
        for (int k = 0; k < nb; k++) drive_bit(lr, bit_for(m, w, k, nb));
    endtask

    task automatic junk_half(input logic lr, input int nb);
        for (int k = 0; k < nb; k++) drive_bit(lr, 1'($urandom));
    endtask

    task automatic burst(input logic [2:0] m, input int nfr, input int nb,
                         input bit vary, input bit orphan, input string rq);
        logic        lh;
        logic [23:0] wl, wr;
        int          nbl, nbr;
        @(negedge clk);
        rst = 1'b1;
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        fmt = m;
        rst = 1'b0;
        req = rq;
        repeat (2) @(negedge clk);
        lh = (m != 3'b011);
        if (orphan) junk_half(lh, 5);
        junk_half(!lh, orphan ? 9 : 3);
        for (int f = 0; f < nfr; f++) begin
            case (f)
                0:       begin wl = 24'h7FFFFF; wr = 24'h800000; end
                1:       begin wl = 24'h000001; wr = 24'h008000; end
                2:       begin wl = 24'h807FFF; wr = 24'hFFFFFF; end
                default: begin wl = 24'($urandom); wr = 24'($urandom); end
            endcase
            nbl = vary ? nb + (f % 4) * 3 : nb;
            nbr = vary ? nb + ((f + 1) % 3) * 5 : nb;
            send_half(lh, m, wl, nbl);
            send_half(!lh, m, wr, nbr);
            q_l.push_back(exp_word(m, wl, nbl));
            q_r.push_back(exp_word(m, wr, nbr));
        end
        junk_half(lh, 2);
        repeat (20) @(negedge clk);
        n_chk++;
        if (q_l.size() != 0) begin
            n_fail++;
            $display("FAIL %s R7: frames not delivered (got %0d pending, expected 0)",
                     rq, q_l.size());
            q_l.delete();
            q_r.delete();
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R9: reset state
        n_chk++;
        if (valid_o !== 1'b0 || left_o !== '0 || right_o !== '0) begin
            n_fail++;
            $display("FAIL R9: reset outputs got %b %h %h, expected 0 0 0",
                     valid_o, left_o, right_o);
        end
        burst(3'b010, 6, 32, 1'b0, 1'b0, "R3 R5 R2");
        burst(3'b010, 4, 16, 1'b0, 1'b0, "R3 pad");
        burst(3'b011, 6, 32, 1'b0, 1'b0, "R4");
        burst(3'b000, 6, 32, 1'b0, 1'b0, "R6 w16");
        burst(3'b000, 4, 16, 1'b0, 1'b0, "R6 w16 short");
        burst(3'b001, 5, 24, 1'b0, 1'b0, "R6 w20");
        burst(3'b001, 4, 20, 1'b0, 1'b0, "R6 w20 short");
        burst(3'b100, 6, 32, 1'b0, 1'b0, "R6 w24");
        burst(3'b010, 8, 24, 1'b1, 1'b0, "R8 head");
        burst(3'b011, 8, 25, 1'b1, 1'b0, "R8 delayed");
        burst(3'b000, 8, 16, 1'b1, 1'b0, "R8 tail");
        burst(3'b010, 4, 32, 1'b0, 1'b1, "R9 orphan");
        burst(3'b101, 4, 32, 1'b0, 1'b0, "R1 spare code");
        burst(3'b111, 3, 28, 1'b0, 1'b0, "R1 spare code");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run still busy (got timeout, expected completion)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule